// File: doc/BRIEF.md
# Priority Interrupt Level Selector

The block merges sixteen external interrupt level lines with a software interrupt word. The word carries two timer-match flags, and these are folded onto level 14 rather than treated as plain levels. The merged vector is weighed against the processor's current priority level. The block keeps one registered request, a hard-interrupt flag plus a trap-type code, which the trap entry logic of the core consumes.

Every input is evaluated combinationally each cycle, and the registered request moves on the next clock edge. Three conditions can leave the request unchanged. A pending vectored interrupt freezes it. An active external-interrupt trap of a higher code blocks a new request. A request whose code equals the stored one is neither re-raised nor changed. The request is cleared when nothing sits above the priority threshold, or when interrupts are disabled globally while a request is standing.

Top module: `pil_sel`

## Requirements
- R1: After reset, `hard_req_o` is 0 and `trap_type_o` is 0.
- R2: The pending vector is `ext_level_i` ORed with `softint_i` bits 15..1. Soft bit 0 (tick match) and soft bit 16 (system-tick match) do not map to levels of their own. If either of them is set, level 14 is pending.
- R3: When `vec_busy_i` is 0 and the pending vector, read as a number, is below 2 shifted left by `cur_pil_i`, then after the next edge `hard_req_o` is 0 and `trap_type_o` is 0. This holds even if interrupts are disabled or a trap is active.
- R4: Otherwise, with `irq_en_i` = 1, the highest pending level L above `cur_pil_i` is chosen. After the next edge `hard_req_o` is 1 and `trap_type_o` is 0x040 | L, so levels 1..15 give 0x041..0x04F.
- R5: While `vec_busy_i` is 1, both outputs keep their values across the edge, whatever the other inputs are.
- R6: If `trap_lvl_i` is above 0, `act_tt_i[8:4]` equals 0x04 and `act_tt_i` is greater than the new code, no new request is taken and both outputs hold. A zero trap level, or an active code from a different class, does not block.
- R7: If the new code equals the stored `trap_type_o`, both outputs hold.
- R8: With `irq_en_i` = 0 and no below-threshold condition, a standing request is cleared to 0 with code 0 after the next edge. With no request standing, the outputs hold.
- R9: The outputs change only on a clock edge, so an input change becomes visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_level_i | input | 16 | External interrupt level lines, bit n is level n |
| softint_i | input | 17 | Software interrupt word: bit 0 is tick match, bit 16 is system-tick match |
| cur_pil_i | input | 4 | Current processor priority level |
| irq_en_i | input | 1 | Global interrupt enable |
| trap_lvl_i | input | 3 | Current trap nesting level |
| act_tt_i | input | 9 | Trap type of the active trap |
| vec_busy_i | input | 1 | A vectored interrupt is pending |
| hard_req_o | output | 1 | Registered hard-interrupt request |
| trap_type_o | output | 9 | Registered trap-type code of the request |

## Verification
The bench builds the block with its default values: sixteen levels, a 17-bit soft word with the timer flags at bits 0 and 16, folding onto level 14, a base code of 0x040 and a 3-bit trap level. With a 4-bit priority level of 15, the threshold 2<<15 lies beyond the 16-bit vector, so the all-ones vector can be shown to be masked. Because the system-tick flag sits above the level field, the bench can show that the flag reaches level 14 only through folding. The 9-bit code leaves room for an active trap of a foreign class (0x05F) above every external code, which exercises the class check of R6.

// File: rtl/pil_sel_pkg.sv
package pil_sel_pkg;
  localparam int unsigned NUM_LVL   = 16;
  localparam int unsigned LVL_W     = $clog2(NUM_LVL);
  localparam int unsigned SOFT_W    = 17;
  localparam int unsigned TICK_BIT  = 0;
  localparam int unsigned STICK_BIT = 16;
  localparam int unsigned FOLD_LVL  = 14;
  localparam int unsigned TT_W      = 9;
  localparam logic [TT_W-1:0] TT_EXT_BASE = 9'h040;

  typedef struct packed {
    logic            req;
    logic [TT_W-1:0] tt;
  } irq_state_t;
endpackage

// File: rtl/pil_pend_merge.sv
module pil_pend_merge #(
  parameter int unsigned NL    = 16,
  parameter int unsigned SW    = 17,
  parameter int unsigned TICK  = 0,
  parameter int unsigned STICK = 16,
  parameter int unsigned FOLD  = 14
) (
  input  logic [NL-1:0] ext_i,
  input  logic [SW-1:0] soft_i,
  output logic [NL-1:0] pend_o
);
  logic [NL-1:0] soft_lv;
  logic [NL-1:0] fold_vec;
  logic          timer_hit;

  for (genvar g = 0; g < NL; g++) begin : g_lv
    if (g == TICK || g == STICK || g >= SW) begin : g_zero
      assign soft_lv[g] = 1'b0;
    end else begin : g_pass
      assign soft_lv[g] = soft_i[g];
    end
  end

  assign timer_hit = soft_i[TICK] | soft_i[STICK];
  assign fold_vec  = timer_hit ? (NL'(1) << FOLD) : '0;
  assign pend_o    = ext_i | soft_lv | fold_vec;

  always_comb begin
    if (timer_hit) begin
      assert_fold_R2: assert (pend_o[FOLD]);
    end
  end
endmodule

// File: rtl/pil_prio_scan.sv
module pil_prio_scan #(
  parameter int unsigned NL = 16,
  parameter int unsigned LW = 4
) (
  input  logic [NL-1:0] pend_i,
  input  logic [LW-1:0] pil_i,
  output logic          below_o,
  output logic          found_o,
  output logic [LW-1:0] lvl_o
);
  logic [NL:0] thresh;

  assign thresh  = (NL+1)'(2) << pil_i;
  assign below_o = {1'b0, pend_i} < thresh;

  // ascending scan, last hit is the highest level above pil
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    for (int i = 0; i < NL; i++) begin
      if (pend_i[i] && (LW'(i) > pil_i)) begin
        found_o = 1'b1;
        lvl_o   = LW'(i);
      end
    end
  end

  always_comb begin
    assert_found_vs_thresh_R3: assert (found_o == !below_o);
    if (found_o) begin
      assert_win_above_pil_R4: assert (pend_i[lvl_o] && (lvl_o > pil_i));
    end
  end
endmodule

// File: rtl/pil_nest_chk.sv
module pil_nest_chk #(
  parameter int unsigned TTW  = 9,
  parameter int unsigned TLW  = 3,
  parameter logic [TTW-1:0] BASE = 9'h040
) (
  input  logic [TLW-1:0] tl_i,
  input  logic [TTW-1:0] act_tt_i,
  input  logic [TTW-1:0] new_tt_i,
  output logic           block_o
);
  logic same_class;

  assign same_class = act_tt_i[TTW-1:4] == BASE[TTW-1:4];
  assign block_o    = (|tl_i) && same_class && (act_tt_i > new_tt_i);
endmodule

// File: rtl/pil_sel.sv
module pil_sel
  import pil_sel_pkg::*;
#(
  parameter int unsigned TL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LVL-1:0] ext_level_i,
  input  logic [SOFT_W-1:0] softint_i,
  input  logic [LVL_W-1:0]  cur_pil_i,
  input  logic              irq_en_i,
  input  logic [TL_W-1:0]   trap_lvl_i,
  input  logic [TT_W-1:0]   act_tt_i,
  input  logic              vec_busy_i,
  output logic              hard_req_o,
  output logic [TT_W-1:0]   trap_type_o
);
  logic [NUM_LVL-1:0] pend;
  logic               below;
  logic               found;
  logic [LVL_W-1:0]   win_lvl;
  logic [TT_W-1:0]    new_tt;
  logic               block;
  irq_state_t         st_q, st_d;

  pil_pend_merge #(
    .NL(NUM_LVL), .SW(SOFT_W), .TICK(TICK_BIT), .STICK(STICK_BIT), .FOLD(FOLD_LVL)
  ) u_merge (
    .ext_i (ext_level_i),
    .soft_i(softint_i),
    .pend_o(pend)
  );

  pil_prio_scan #(.NL(NUM_LVL), .LW(LVL_W)) u_scan (
    .pend_i (pend),
    .pil_i  (cur_pil_i),
    .below_o(below),
    .found_o(found),
    .lvl_o  (win_lvl)
  );

  assign new_tt = TT_EXT_BASE | {{(TT_W-LVL_W){1'b0}}, win_lvl};

  pil_nest_chk #(.TTW(TT_W), .TLW(TL_W), .BASE(TT_EXT_BASE)) u_nest (
    .tl_i    (trap_lvl_i),
    .act_tt_i(act_tt_i),
    .new_tt_i(new_tt),
    .block_o (block)
  );

  always_comb begin
    st_d = st_q;
    if (!vec_busy_i) begin
      if (below) begin
        st_d = '0;
      end else if (irq_en_i) begin
        if (found && !block && (st_q.tt != new_tt)) begin
          st_d.req = 1'b1;
          st_d.tt  = new_tt;
        end
      end else if (st_q.req) begin
        st_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign hard_req_o  = st_q.req;
  assign trap_type_o = st_q.tt;

  assert_busy_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_busy_i |=> ($stable(hard_req_o) && $stable(trap_type_o)));

  assert_below_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_busy_i && below) |=> (!hard_req_o && trap_type_o == '0));

  assert_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_busy_i && !below && irq_en_i && !block && trap_type_o != new_tt)
    |=> (hard_req_o && trap_type_o == $past(new_tt)));

  assert_req_class_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_req_o |-> (trap_type_o[TT_W-1:4] == TT_EXT_BASE[TT_W-1:4] && trap_type_o[3:0] != 4'd0));

  assert_nest_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_busy_i && !below && irq_en_i && block)
    |=> ($stable(hard_req_o) && $stable(trap_type_o)));

  assert_same_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_busy_i && !below && irq_en_i && trap_type_o == new_tt)
    |=> ($stable(hard_req_o) && $stable(trap_type_o)));

  assert_disable_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_busy_i && !irq_en_i && hard_req_o) |=> (!hard_req_o && trap_type_o == '0));
endmodule

// File: tb/pil_sel_tb_top.sv
`timescale 1ns/1ps
module pil_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ext_level_i = '0;
  logic [16:0] softint_i = '0;
  logic [3:0]  cur_pil_i = '0;
  logic        irq_en_i = 1'b1;
  logic [2:0]  trap_lvl_i = '0;
  logic [8:0]  act_tt_i = '0;
  logic        vec_busy_i = 1'b0;
  logic        hard_req_o;
  logic [8:0]  trap_type_o;

  typedef struct {
    logic       req;
    logic [8:0] tt;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pil_sel dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_level_i(ext_level_i), .softint_i(softint_i),
    .cur_pil_i(cur_pil_i), .irq_en_i(irq_en_i), .trap_lvl_i(trap_lvl_i),
    .act_tt_i(act_tt_i), .vec_busy_i(vec_busy_i),
    .hard_req_o(hard_req_o), .trap_type_o(trap_type_o)
  );

  task automatic cmp(input logic er, input logic [8:0] ett, input string tag);
    checks++;
    if (hard_req_o !== er || trap_type_o !== ett) begin
      failures++;
      $display("FAIL %s actual req=%0b tt=0x%03h expected req=%0b tt=0x%03h",
               tag, hard_req_o, trap_type_o, er, ett);
    end
  endtask

  // driver: inputs already set at this negedge; expect result after next posedge
  task automatic go(input logic er, input logic [8:0] ett, input string tag);
    exp_t e;
    e.req = er; e.tt = ett; e.tag = tag;
    q.push_back(e);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.req, e.tt, e.tag);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cmp(1'b0, 9'h000, "R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp(1'b0, 9'h000, "R1 after release");

    ext_level_i = 16'h0020;                 go(1'b1, 9'h045, "R4 single level 5");
    ext_level_i = 16'h0228;
    #1 cmp(1'b1, 9'h045, "R9 no change before edge");
    go(1'b1, 9'h049, "R4 highest of 3,5,9");
    ext_level_i = 16'h0; softint_i = 17'h00080; go(1'b1, 9'h047, "R2 soft level 7");
    softint_i = 17'h00001;                  go(1'b1, 9'h04E, "R2 tick folds to 14");
    softint_i = 17'h10000;                  go(1'b1, 9'h04E, "R7 stick folds to 14 same code holds");
    softint_i = 17'h0;

    ext_level_i = 16'h0200; cur_pil_i = 4'd9; go(1'b0, 9'h000, "R3 level equal pil masked");
    ext_level_i = 16'h0400;                 go(1'b1, 9'h04A, "R4 level pil+1 wins");
    ext_level_i = 16'hFFFF; cur_pil_i = 4'd15; go(1'b0, 9'h000, "R3 pil 15 masks all");
    cur_pil_i = 4'd0; ext_level_i = 16'h0008; go(1'b1, 9'h043, "R4 level 3 at pil 0");
    ext_level_i = 16'h0001;                 go(1'b0, 9'h000, "R3 level 0 never wins");
    cur_pil_i = 4'd4; ext_level_i = 16'h0014; go(1'b0, 9'h000, "R3 levels 2,4 at pil 4");
    ext_level_i = 16'h0030;                 go(1'b1, 9'h045, "R4 level 5 at pil 4");
    cur_pil_i = 4'd0;

    ext_level_i = 16'h0040;                 go(1'b1, 9'h046, "R4 level 6");
    vec_busy_i = 1'b1; ext_level_i = 16'h1000; go(1'b1, 9'h046, "R5 busy holds new level");
    ext_level_i = 16'h0;                    go(1'b1, 9'h046, "R5 busy holds below threshold");
    irq_en_i = 1'b0;                        go(1'b1, 9'h046, "R5 busy holds when disabled");
    irq_en_i = 1'b1; vec_busy_i = 1'b0; ext_level_i = 16'h1000; go(1'b1, 9'h04C, "R5 release evaluates");

    irq_en_i = 1'b0;                        go(1'b0, 9'h000, "R8 disable clears");
    ext_level_i = 16'h2000;                 go(1'b0, 9'h000, "R8 disabled stays clear");
    irq_en_i = 1'b1;                        go(1'b1, 9'h04D, "R8 re-enable raises");

    trap_lvl_i = 3'd1; act_tt_i = 9'h04E; ext_level_i = 16'h0800; go(1'b1, 9'h04D, "R6 higher active blocks");
    act_tt_i = 9'h04A;                      go(1'b1, 9'h04B, "R6 lower active allows");
    trap_lvl_i = 3'd0; act_tt_i = 9'h04F; ext_level_i = 16'h0020; go(1'b1, 9'h045, "R6 trap level 0 allows");
    trap_lvl_i = 3'd2; act_tt_i = 9'h05F; ext_level_i = 16'h0008; go(1'b1, 9'h043, "R6 other class allows");
    act_tt_i = 9'h04F; ext_level_i = 16'h0;  go(1'b0, 9'h000, "R3 below clears despite block");
    trap_lvl_i = 3'd0; act_tt_i = 9'h0;

    @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule